// File: doc/BRIEF.md
# Wait-Pin Driven Access Timer

This block sets the length of one external memory access for the chip-select that is currently active. A start strobe loads a programmable wait-state count. There is one count for reads, one for writes and one for page/burst accesses. The block then counts down to zero. When the count expires, the access can be held longer by one of two shared external wait pins. Each chip-select picks its own pin and that pin's active level, so one device's wait signal never stalls an access to a different device.

Both wait pins pass through a two-stage synchronizer before use. Wait monitoring is switched on separately for reads and for writes on each chip-select. A page/burst access follows the read enable. A bounded stall counter ends an access whose wait pin never releases and flags it as a timeout. A one-cycle completion strobe tells the surrounding controller when to capture data or end the cycle.

The controller is a three-state machine. **IDLE** accepts a start. **COUNT** runs the wait-state counter. **STALL** monitors the selected wait pin. The transitions are:
- IDLE→COUNT on an accepted start.
- COUNT→COUNT while the count is non-zero.
- COUNT→IDLE on expiry when no wait is seen.
- COUNT→STALL on expiry when monitoring is on and the pin reads active.
- STALL→IDLE when the pin reads inactive, or when the stall limit is reached.

Top module: `wait_access_timer`

## Requirements
- R1: After reset `busy`, `done` and `tmo_err` are all 0.
- R2: With wait monitoring off, a read accepted in cycle c raises `done` for one cycle in cycle c+1+N, where N is `rd_time`. N = 0 therefore completes one cycle after start.
- R3: `acc_kind` encoding: 2'b01 is a write and takes `wr_time`. 2'b10 is a page/burst access and takes `pg_time`. 2'b00 and 2'b11 are reads and take `rd_time`.
- R4: `wait_sel[cs]` picks the wait input for chip-select cs. A value of 0 selects `wait0` and 1 selects `wait1`.
- R5: `wait_pol[cs]` gives the active level of the selected pin. A value of 1 means active-high and 0 means active-low.
- R6: An active level on the wait pin that the active chip-select does not select has no effect on completion time.
- R7: Monitoring is enabled by `wr_wait_en[cs]` for writes and by `rd_wait_en[cs]` for reads and page accesses. When it is disabled, the access completes exactly at the programmed count, whatever the pins do.
- R8: The pin is examined only in the expiry cycle and after it. While it reads active, the access is held. `done` rises in the first cycle the synchronized pin reads inactive, which is two clock edges after the pin changes.
- R9: If the pin stays active for MAX_WAIT stall cycles, `done` and `tmo_err` rise together in the MAX_WAIT-th stall cycle. `tmo_err` is never high without `done`.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle. A start while busy is ignored. `done` is a single-cycle pulse and is followed by an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Access start strobe, accepted when idle |
| cs_idx | input | 3 | Chip-select of the access |
| acc_kind | input | 2 | Access kind (read/write/page) |
| rd_time | input | 5 | Read wait-state count |
| wr_time | input | 5 | Write wait-state count |
| pg_time | input | 5 | Page/burst wait-state count |
| wait_sel | input | 8 | Per-CS wait pin choice |
| wait_pol | input | 8 | Per-CS wait active level |
| rd_wait_en | input | 8 | Per-CS wait monitoring for reads/pages |
| wr_wait_en | input | 8 | Per-CS wait monitoring for writes |
| wait0 | input | 1 | External wait pin 0 (asynchronous) |
| wait1 | input | 1 | External wait pin 1 (asynchronous) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion / capture strobe |
| tmo_err | output | 1 | Stall limit reached, coincident with done |

## Verification
Accesses run with monitoring disabled for each of the three kinds and for a zero count. These runs tell the count selection apart from the wait logic. Next, each chip-select configuration is held against a pin that is active-high on one device and active-low on another. Runs with the other, unselected pin driven active show that pin selection and polarity are decoded per chip-select rather than shared. A pin released partway through a stall checks the two-edge synchronizer latency against the completion cycle. A pin that never releases checks the timeout. A start repeated while busy checks that it is dropped.

// File: rtl/wat_pkg.sv
package wat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_STALL = 2'd2
    } wat_state_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_PAGE  = 2'b10,
        KIND_RSVD  = 2'b11
    } acc_kind_e;
endpackage

// File: rtl/wat_sync.sv
module wat_sync #(
    parameter int N_PINS = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_async,
    output logic [N_PINS-1:0] pin_sync
);
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pin_async[p]};
        end
        assign pin_sync[p] = chain[STAGES-1];
    end
endmodule

// File: rtl/wat_wait_mux.sv
module wat_wait_mux #(
    parameter int NUM_CS = 8,
    localparam int CSW   = $clog2(NUM_CS)
) (
    input  logic [1:0]        pin_sync,
    input  logic [CSW-1:0]    cs,
    input  logic [NUM_CS-1:0] sel,
    input  logic [NUM_CS-1:0] pol,
    output logic              wait_act
);
    logic [NUM_CS-1:0] act_per_cs;

    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
        assign act_per_cs[c] = (sel[c] ? pin_sync[1] : pin_sync[0]) == pol[c];
    end

    assign wait_act = act_per_cs[cs];
endmodule

// File: rtl/wat_fsm.sv
module wat_fsm
    import wat_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int MAX_WAIT = 16,
    localparam int TMO_W   = (MAX_WAIT > 2) ? $clog2(MAX_WAIT) : 1,
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(MAX_WAIT - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             mon_en,
    input  logic             wait_act,
    output logic             busy,
    output logic             done,
    output logic             tmo_err
);
    wat_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic             mon_q;
    logic             stall_now;
    logic             tmo_hit;

    assign stall_now = mon_q && wait_act;
    assign tmo_hit   = (tmo_cnt == TMO_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            tmo_cnt <= '0;
            mon_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_COUNT;
                        cnt   <= load_cnt;
                        mon_q <= mon_en;
                    end
                end
                ST_COUNT: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (stall_now) begin
                        state   <= ST_STALL;
                        tmo_cnt <= '0;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_STALL: begin
                    if (!wait_act || tmo_hit) state <= ST_IDLE;
                    else                      tmo_cnt <= tmo_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        tmo_err = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_COUNT: begin
                busy = 1'b1;
                done = (cnt == '0) && !stall_now;
            end
            ST_STALL: begin
                busy    = 1'b1;
                done    = !wait_act || tmo_hit;
                tmo_err = wait_act && tmo_hit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wait_access_timer.sv
module wait_access_timer
    import wat_pkg::*;
#(
    parameter int NUM_CS   = 8,
    parameter int CNT_W    = 5,
    parameter int MAX_WAIT = 16,
    localparam int CSW     = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CSW-1:0]    cs_idx,
    input  logic [1:0]        acc_kind,
    input  logic [CNT_W-1:0]  rd_time,
    input  logic [CNT_W-1:0]  wr_time,
    input  logic [CNT_W-1:0]  pg_time,
    input  logic [NUM_CS-1:0] wait_sel,
    input  logic [NUM_CS-1:0] wait_pol,
    input  logic [NUM_CS-1:0] rd_wait_en,
    input  logic [NUM_CS-1:0] wr_wait_en,
    input  logic              wait0,
    input  logic              wait1,
    output logic              busy,
    output logic              done,
    output logic              tmo_err
);
    logic [1:0]       pin_sync;
    logic [CSW-1:0]   cs_q;
    logic             accept;
    logic [CNT_W-1:0] time_sel;
    logic             mon_sel;
    logic             wait_act;

    assign accept = start && !busy;

    always_comb begin
        unique case (acc_kind_e'(acc_kind))
            KIND_WRITE: begin
                time_sel = wr_time;
                mon_sel  = wr_wait_en[cs_idx];
            end
            KIND_PAGE: begin
                time_sel = pg_time;
                mon_sel  = rd_wait_en[cs_idx];
            end
            KIND_READ, KIND_RSVD: begin
                time_sel = rd_time;
                mon_sel  = rd_wait_en[cs_idx];
            end
            default: begin
                time_sel = rd_time;
                mon_sel  = rd_wait_en[cs_idx];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cs_q <= '0;
        else if (accept) cs_q <= cs_idx;
    end

    wat_sync #(.N_PINS(2), .STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async ({wait1, wait0}),
        .pin_sync  (pin_sync)
    );

    wat_wait_mux #(.NUM_CS(NUM_CS)) u_mux (
        .pin_sync (pin_sync),
        .cs       (cs_q),
        .sel      (wait_sel),
        .pol      (wait_pol),
        .wait_act (wait_act)
    );

    wat_fsm #(.CNT_W(CNT_W), .MAX_WAIT(MAX_WAIT)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .load_cnt (time_sel),
        .mon_en   (mon_sel),
        .wait_act (wait_act),
        .busy     (busy),
        .done     (done),
        .tmo_err  (tmo_err)
    );
endmodule

// File: rtl/wat_checker.sv
module wat_checker #(
    parameter int CNT_W    = 5,
    parameter int MAX_WAIT = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic tmo_err
);
    localparam int BUSY_LIMIT = (1 << CNT_W) + MAX_WAIT + 1;
    int busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);              // R10
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);             // R10
    AST_DONE_IN_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);               // R10
    AST_START_TAKEN:    assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);   // R2
    AST_ERR_WITH_DONE:  assert property (@(posedge clk) disable iff (!rst_n) tmo_err |-> done);            // R9
    AST_BUSY_BOUNDED:   assert property (@(posedge clk) disable iff (!rst_n) busy_run <= BUSY_LIMIT);      // R9
endmodule

bind wait_access_timer wat_checker #(.CNT_W(CNT_W), .MAX_WAIT(MAX_WAIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .tmo_err (tmo_err)
);

// File: tb/tb_wait_access_timer.sv
`timescale 1ns/1ps
module tb_wait_access_timer;
    localparam int MAX_WAIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] cs_idx = '0;
    logic [1:0] acc_kind = '0;
    logic [4:0] rd_time = 5'd3;
    logic [4:0] wr_time = 5'd6;
    logic [4:0] pg_time = 5'd1;
    logic [7:0] wait_sel, wait_pol, rd_wait_en, wr_wait_en;
    logic       wait0 = 1'b0;
    logic       wait1 = 1'b0;
    logic       busy, done, tmo_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    wait_access_timer #(.MAX_WAIT(MAX_WAIT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cs_idx(cs_idx), .acc_kind(acc_kind),
        .rd_time(rd_time), .wr_time(wr_time), .pg_time(pg_time),
        .wait_sel(wait_sel), .wait_pol(wait_pol), .rd_wait_en(rd_wait_en), .wr_wait_en(wr_wait_en),
        .wait0(wait0), .wait1(wait1), .busy(busy), .done(done), .tmo_err(tmo_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic w0, input logic w1);
        @(negedge clk);
        wait0 = w0;
        wait1 = w1;
        repeat (3) @(negedge clk);
    endtask

    // Runs one access; n counts negedges after the accepting edge.
    task automatic run_access(input logic [2:0] cs, input logic [1:0] kind, input int exp_n,
                              input bit exp_err, input int rel_at, input logic r0, input logic r1,
                              input int restart_at, input string req);
        int got_n;
        bit got_err;
        got_n   = -1;
        got_err = 1'b0;
        @(negedge clk);
        cs_idx   = cs;
        acc_kind = kind;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 1; n <= 60; n++) begin
            if (n > 1) @(negedge clk);
            if (n == 1) chk(busy == 1'b1, {req, " busy"}, int'(busy), 1);
            if (done && got_n < 0) begin
                got_n   = n;
                got_err = tmo_err;
            end
            if (n == rel_at) begin
                wait0 = r0;
                wait1 = r1;
            end
            if (n == restart_at) start = 1'b1;
            else                 start = 1'b0;
            if (got_n >= 0) break;
        end
        start = 1'b0;
        chk(got_n == exp_n, {req, " done cycle"}, got_n, exp_n);
        chk(got_err == exp_err, {req, " tmo_err"}, int'(got_err), int'(exp_err));
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, {req, " idle after done"}, int'(busy), 0);
    endtask

    task automatic t_reset;
        chk(busy == 0 && done == 0 && tmo_err == 0, "R1 reset outputs", int'({busy, done, tmo_err}), 0);
    endtask

    task automatic t_counts;
        set_pins(1'b0, 1'b1);
        run_access(3'd2, 2'b00, 4, 0, 0, 0, 0, 0, "R2 read N=3");
        rd_time = 5'd0;
        run_access(3'd2, 2'b00, 1, 0, 0, 0, 0, 0, "R2 read N=0");
        rd_time = 5'd3;
        run_access(3'd2, 2'b01, 7, 0, 0, 0, 0, 0, "R3 write");
        run_access(3'd2, 2'b10, 2, 0, 0, 0, 0, 0, "R3 page");
        run_access(3'd2, 2'b11, 4, 0, 0, 0, 0, 0, "R3 reserved as read");
    endtask

    task automatic t_select;
        set_pins(1'b1, 1'b0);
        run_access(3'd0, 2'b00, 8, 0, 6, 1'b0, 1'b0, 0, "R4 R8 cs0 wait0 release");
        set_pins(1'b0, 1'b1);
        run_access(3'd0, 2'b00, 4, 0, 0, 0, 0, 0, "R6 cs0 ignores wait1");
        set_pins(1'b0, 1'b1);
        run_access(3'd3, 2'b00, 4 + MAX_WAIT, 1, 0, 0, 0, 0, "R9 cs3 timeout");
        set_pins(1'b1, 1'b0);
        run_access(3'd3, 2'b00, 4, 0, 0, 0, 0, 0, "R6 cs3 ignores wait0");
    endtask

    task automatic t_polarity;
        set_pins(1'b1, 1'b0);
        run_access(3'd1, 2'b00, 8, 0, 6, 1'b1, 1'b1, 0, "R5 cs1 active-low release");
        set_pins(1'b0, 1'b1);
        run_access(3'd1, 2'b00, 4, 0, 0, 0, 0, 0, "R5 cs1 high is inactive");
        set_pins(1'b0, 1'b0);
        run_access(3'd1, 2'b01, 7 + MAX_WAIT, 1, 0, 0, 0, 0, "R9 R5 cs1 write timeout");
    endtask

    task automatic t_disable;
        set_pins(1'b1, 1'b0);
        run_access(3'd0, 2'b01, 7, 0, 0, 0, 0, 0, "R7 cs0 write monitor off");
        set_pins(1'b0, 1'b0);
        run_access(3'd2, 2'b00, 4, 0, 0, 0, 0, 0, "R7 cs2 read monitor off");
    endtask

    task automatic t_restart;
        set_pins(1'b0, 1'b0);
        run_access(3'd2, 2'b00, 4, 0, 0, 0, 0, 2, "R10 start while busy");
        repeat (8) begin
            @(negedge clk);
            chk(done == 1'b0 && busy == 1'b0, "R10 no extra access", int'(done), 0);
        end
    endtask

    initial begin
        wait_sel   = 8'b0000_1010;
        wait_pol   = 8'b0000_1001;
        rd_wait_en = 8'b0000_1011;
        wr_wait_en = 8'b0000_0010;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counts();
        t_select();
        t_polarity();
        t_disable();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule